// File: doc/BRIEF.md
# Triggered Signal Capture Buffer

This block is a small on-chip capture engine in the manner of an embedded logic analyzer. On every rising edge of its clock it registers a group of probe signals. Once armed, it writes those registered samples into a circular memory, one sample per clock. It then waits for an edge on one selected probe bit. When the edge arrives it keeps recording until the chosen share of the buffer after the trigger is full, stops, and raises a done flag.

The user picks one of three trigger placements when arming. Each placement splits the buffer between history before the trigger and data after it. The block ignores the trigger until the history part of the buffer has been filled at least once, so every stored pre-trigger sample is real.

After completion a read port returns the stored samples, oldest first. The port is addressed by an offset from the oldest sample, and the trigger sample sits at the offset equal to the pre-trigger length. The depth is a build-time power of two, at least 16. The capture window in time is the depth multiplied by the clock period.

Top module: `trig_capture_buf`

## Requirements
- R1: After reset, capturing_o, waiting_o, done_o and rd_data_o are all zero, and the block is idle.
- R2: A one-cycle arm_i pulse while idle or done starts a capture in the next cycle. While capturing_o is high, the block stores one sample per clock. The probe value present at clock edge k is stored at edge k+1.
- R3: After arming, waiting_o rises only once the pre-trigger count of samples has been stored. Any trigger edge before that point is ignored.
- R4: The pre-trigger count is taken from mode_i. Code 0 gives floor(DEPTH·12/100), code 2 gives floor(DEPTH·88/100), and codes 1 and 3 give DEPTH/2. The post-trigger count, which includes the trigger sample, is DEPTH minus the pre-trigger count.
- R5: The trigger is an edge on probe bit trig_sel_i between two consecutive stored samples. trig_rise_i=0 selects a falling edge (1 then 0) and trig_rise_i=1 selects a rising edge (0 then 1). The second of the two samples is the trigger sample.
- R6: After the trigger sample, exactly post-count minus one further samples are stored. capturing_o and waiting_o then drop, done_o rises, and done_o stays high until the next arm.
- R7: While done, rd_data_o returns, one clock after rd_addr_i is applied, the sample at offset rd_addr_i from the oldest stored sample. Offset pre-count is the trigger sample, and offsets run in capture order.
- R8: An arm_i pulse during a capture has no effect on the capture in progress.
- R9: An arm_i pulse while done clears done_o and starts a fresh capture with counters restarted.
- R10: mode_i, trig_sel_i and trig_rise_i are latched at the arm. Changes to them during a capture have no effect on that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge only |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_i | input | PROBE_W | Signals under observation |
| arm_i | input | 1 | Start a capture (idle or done only) |
| mode_i | input | 2 | Trigger placement code, latched at arm |
| trig_sel_i | input | SEL_W | Index of the probe bit to trigger on |
| trig_rise_i | input | 1 | 1: rising edge, 0: falling edge |
| rd_addr_i | input | log2(DEPTH) | Read offset from the oldest sample |
| rd_data_o | output | PROBE_W | Stored sample, one clock after the address |
| capturing_o | output | 1 | Samples are being stored |
| waiting_o | output | 1 | Pre-trigger history full, awaiting trigger |
| done_o | output | 1 | Capture complete, buffer readable |

## Verification
The embedded properties check the following on every cycle:
- the write pointer steps by one while capturing;
- waiting begins exactly when the stored count equals the latched pre-trigger length;
- waiting persists until a detected edge;
- every trigger hit coincides with a change between consecutive samples;
- done is entered only from the post-trigger phase and is held;
- an arm pulse during the post phase cannot reset the capture.

Some behaviours appear only in the bench's scenarios, which compare against a behavioural model. These are the exact pre/post split for each mode code, the falling-versus-rising selection, the ignoring of early edges during the history fill, the latching of settings at arm, and the oldest-first readout with the trigger sample at the right offset.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_POST,
        ST_DONE
    } cap_state_e;

    // Samples kept ahead of the trigger for a placement code.
    function automatic int pre_len(input logic [1:0] mode, input int depth);
        case (mode)
            2'd0:    return (depth * 12) / 100;
            2'd2:    return (depth * 88) / 100;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/cap_probe_pipe.sv
module cap_probe_pipe #(
    parameter int PROBE_W = 8,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               rise_i,
    output logic [PROBE_W-1:0] samp_o,
    output logic               hit_o
);

    typedef struct packed {
        logic [PROBE_W-1:0] cur;
        logic [PROBE_W-1:0] prev;
    } pipe_t;

    pipe_t pq, pd;

    always_comb begin
        pd      = pq;
        pd.cur  = probe_i;
        pd.prev = pq.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pq <= '0;
        else        pq <= pd;
    end

    logic bit_now, bit_was;
    always_comb begin
        bit_now = pq.cur[sel_i];
        bit_was = pq.prev[sel_i];
        hit_o   = rise_i ? (!bit_was && bit_now) : (bit_was && !bit_now);
    end

    assign samp_o = pq.cur;

    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (samp_o != $past(samp_o))); // R5

endmodule

// File: rtl/cap_store.sv
module cap_store #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [AW-1:0]      wa_i,
    input  logic [PROBE_W-1:0] wd_i,
    input  logic [AW-1:0]      base_i,
    input  logic [AW-1:0]      off_i,
    output logic [PROBE_W-1:0] rd_o
);

    logic [PROBE_W-1:0] mem [DEPTH];
    logic [PROBE_W-1:0] rd_d, rd_q;
    logic [AW-1:0]      ra;

    always_ff @(posedge clk) begin
        if (we_i) mem[wa_i] <= wd_i;
    end

    always_comb begin
        ra   = base_i + off_i;
        rd_d = mem[ra];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_o = rd_q;

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int SEL_W   = 3,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [1:0]       mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             rise_i,
    input  logic             hit_i,
    output logic             we_o,
    output logic [AW-1:0]    wa_o,
    output logic [AW-1:0]    base_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             rise_o,
    output logic             capturing_o,
    output logic             waiting_o,
    output logic             done_o
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] PRE_LO  = CW'(pre_len(2'd0, DEPTH));
    localparam logic [CW-1:0] PRE_MID = CW'(pre_len(2'd1, DEPTH));
    localparam logic [CW-1:0] PRE_HI  = CW'(pre_len(2'd2, DEPTH));

    typedef struct packed {
        cap_state_e       st;
        logic [AW-1:0]    wr_ptr;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    pre;
        logic [CW-1:0]    left;
        logic [AW-1:0]    trig;
        logic [SEL_W-1:0] sel;
        logic             rise;
    } ctrl_t;

    ctrl_t cq, cd;
    logic  we_d;
    logic [CW-1:0] pre_pick, cnt_inc;

    always_comb begin
        case (mode_i)
            2'd0:    pre_pick = PRE_LO;
            2'd2:    pre_pick = PRE_HI;
            default: pre_pick = PRE_MID;
        endcase
        cnt_inc = cq.cnt + 1'b1;
    end

    always_comb begin
        cd   = cq;
        we_d = 1'b0;
        case (cq.st)
            ST_IDLE, ST_DONE: begin
                if (arm_i) begin
                    cd.st     = ST_FILL;
                    cd.wr_ptr = '0;
                    cd.cnt    = '0;
                    cd.left   = '0;
                    cd.pre    = pre_pick;
                    cd.sel    = sel_i;
                    cd.rise   = rise_i;
                end
            end
            ST_FILL: begin
                we_d      = 1'b1;
                cd.wr_ptr = cq.wr_ptr + 1'b1;
                cd.cnt    = cnt_inc;
                if (cnt_inc == cq.pre) cd.st = ST_WAIT;
            end
            ST_WAIT: begin
                we_d      = 1'b1;
                cd.wr_ptr = cq.wr_ptr + 1'b1;
                if (hit_i) begin
                    cd.st   = ST_POST;
                    cd.trig = cq.wr_ptr;
                    cd.left = DEPTH_C - cq.pre - 1'b1;
                end
            end
            ST_POST: begin
                we_d      = 1'b1;
                cd.wr_ptr = cq.wr_ptr + 1'b1;
                cd.left   = cq.left - 1'b1;
                if (cq.left == CW'(1)) cd.st = ST_DONE;
            end
            default: cd.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq    <= '0;
            cq.st <= ST_IDLE;
        end else begin
            cq <= cd;
        end
    end

    assign we_o        = we_d;
    assign wa_o        = cq.wr_ptr;
    assign base_o      = cq.trig - cq.pre[AW-1:0];
    assign sel_o       = cq.sel;
    assign rise_o      = cq.rise;
    assign capturing_o = (cq.st == ST_FILL) || (cq.st == ST_WAIT) || (cq.st == ST_POST);
    assign waiting_o   = (cq.st == ST_WAIT);
    assign done_o      = (cq.st == ST_DONE);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        capturing_o |=> (cq.wr_ptr == $past(cq.wr_ptr) + 1'b1)); // R2
    AST_WAIT_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(waiting_o) |-> (cq.cnt == cq.pre)); // R3
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_o && !hit_i) |=> waiting_o); // R5
    AST_DONE_FROM_POST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(cq.st) == ST_POST)); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> done_o); // R6
    AST_ARM_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ((cq.st == ST_POST) && arm_i) |=> ((cq.st == ST_POST) || (cq.st == ST_DONE))); // R8

endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 64,
    localparam int SEL_W  = (PROBE_W > 1) ? $clog2(PROBE_W) : 1,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic               arm_i,
    input  logic [1:0]         mode_i,
    input  logic [SEL_W-1:0]   trig_sel_i,
    input  logic               trig_rise_i,
    input  logic [AW-1:0]      rd_addr_i,
    output logic [PROBE_W-1:0] rd_data_o,
    output logic               capturing_o,
    output logic               waiting_o,
    output logic               done_o
);

    logic [PROBE_W-1:0] samp;
    logic               hit, we, rise_l;
    logic [AW-1:0]      wa, base;
    logic [SEL_W-1:0]   sel_l;

    cap_probe_pipe #(.PROBE_W(PROBE_W), .SEL_W(SEL_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .probe_i(probe_i),
        .sel_i(sel_l), .rise_i(rise_l), .samp_o(samp), .hit_o(hit)
    );

    cap_ctrl #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .mode_i(mode_i),
        .sel_i(trig_sel_i), .rise_i(trig_rise_i), .hit_i(hit),
        .we_o(we), .wa_o(wa), .base_o(base), .sel_o(sel_l), .rise_o(rise_l),
        .capturing_o(capturing_o), .waiting_o(waiting_o), .done_o(done_o)
    );

    cap_store #(.PROBE_W(PROBE_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(we), .wa_i(wa), .wd_i(samp),
        .base_i(base), .off_i(rd_addr_i), .rd_o(rd_data_o)
    );

endmodule

// File: tb/tb_trig_capture_buf.sv
module tb_trig_capture_buf;
    localparam int PW = 8;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);

    logic clk = 0, rst_n = 0;
    logic [PW-1:0] probe_i = 0;
    logic arm_i = 0, trig_rise_i = 0;
    logic [1:0] mode_i = 0;
    logic [2:0] trig_sel_i = 0;
    logic [AW-1:0] rd_addr_i = 0;
    logic [PW-1:0] rd_data_o;
    logic capturing_o, waiting_o, done_o;

    int total = 0, bad = 0, cyc = 0;
    bit cmp_en = 0;

    always #2.5 clk = ~clk;

    trig_capture_buf #(.PROBE_W(PW), .DEPTH(DEPTH)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 fill, 2 wait, 3 post, 4 done
    int mst = 0, mcnt, mpre, mleft, mtrig, msel;
    bit mrise;
    logic [PW-1:0] ms = 0, mp = 0;
    logic [PW-1:0] mq[$];

    function automatic int pre_for(input int m);
        if (m == 0) return DEPTH * 12 / 100;
        if (m == 2) return DEPTH * 88 / 100;
        return DEPTH / 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; ms = 0; mp = 0;
        end else begin
            bit pb, sb, edge_ok;
            pb = mp[msel]; sb = ms[msel];
            edge_ok = mrise ? (!pb && sb) : (pb && !sb);
            case (mst)
                0, 4: if (arm_i) begin
                    mst = 1; mcnt = 0; mq.delete();
                    mpre = pre_for(int'(mode_i)); msel = int'(trig_sel_i); mrise = trig_rise_i;
                end
                1: begin mq.push_back(ms); mcnt++; if (mcnt == mpre) mst = 2; end
                2: begin
                    mq.push_back(ms);
                    if (edge_ok) begin mtrig = mq.size() - 1; mleft = DEPTH - mpre - 1; mst = 3; end
                end
                3: begin mq.push_back(ms); mleft--; if (mleft == 0) mst = 4; end
                default: mst = 0;
            endcase
            mp = ms; ms = probe_i;
        end
    end

    always @(negedge clk) if (cmp_en) begin
        chk(capturing_o == (mst >= 1 && mst <= 3), "R2 capturing", capturing_o, mst);
        chk(waiting_o == (mst == 2), "R3/R4 waiting", waiting_o, mst);
        chk(done_o == (mst == 4), "R6 done", done_o, mst);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    int k = 0;
    task automatic tick(input logic [PW-1:0] v);
        @(negedge clk); probe_i = v; k++;
    endtask

    task automatic arm();
        @(negedge clk); arm_i = 1;
        @(negedge clk); arm_i = 0;
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); rd_addr_i = AW'(a);
            @(negedge clk);
            chk(rd_data_o == mq[mtrig - mpre + a], tag, rd_data_o, mq[mtrig - mpre + a]);
            if (a == mpre)
                chk(rd_data_o == mq[mtrig], "R5 trigger sample", rd_data_o, mq[mtrig]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!capturing_o && !waiting_o && !done_o, "R1 flags", {capturing_o, waiting_o, done_o}, 0);
        chk(rd_data_o == 0, "R1 rd_data", rd_data_o, 0);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;

        // A: pre placement, falling on bit 0 of a counter
        mode_i = 2'd0; trig_sel_i = 0; trig_rise_i = 0;
        arm();
        k = 0;
        while (!done_o && k < 400) tick(PW'(k));
        chk(done_o, "R6 A done", done_o, 1);
        chk(mpre == 7, "R4 pre split", mpre, 7);
        read_all("R7 A readout");

        // B: re-arm from done; code 3 acts as center, rising on bit 3
        mode_i = 2'd3; trig_sel_i = 3; trig_rise_i = 1;
        @(negedge clk); arm_i = 1;
        @(negedge clk); arm_i = 0;
        chk(!done_o && capturing_o, "R9 rearm", done_o, 0);
        mode_i = 2'd0; trig_sel_i = 1; trig_rise_i = 0;   // R10: must not matter
        k = 0;
        while (!done_o && k < 400) begin
            tick(PW'(k * 3));
            if (k == 45) begin
                arm_i = 1; tick(PW'(k * 3)); arm_i = 0;
                chk(capturing_o, "R8 arm ignored", capturing_o, 1);
            end
        end
        chk(done_o, "R6 B done", done_o, 1);
        chk(mpre == DEPTH / 2, "R4 center split", mpre, DEPTH / 2);
        read_all("R7/R10 B readout");

        // C: post placement, falling on bit 7; early dip is ignored
        mode_i = 2'd2; trig_sel_i = 7; trig_rise_i = 0;
        arm();
        k = 0;
        while (!done_o && k < 400) begin
            logic hi;
            hi = !((k >= 3 && k <= 4) || k >= 120);
            tick({hi, 7'(k)});
            if (k == 100) chk(waiting_o, "R3 early edge ignored", waiting_o, 1);
        end
        chk(done_o, "R6 C done", done_o, 1);
        chk(mpre == 56, "R4 post split", mpre, 56);
        read_all("R7 C readout");

        cmp_en = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule